// File: doc/BRIEF.md
# Status Register and Write-Permission Guard

This block holds the 8-bit status byte of a serial non-volatile memory and decides whether each array write or status write may go ahead. The command decoder tells it about write-enable set and clear commands, status-write requests with their data byte, and the end of each memory access. The program timer tells it when an internal write cycle is busy. The block returns the status byte for status reads and registered permit flags. The command decoder uses these flags to accept or refuse a write.

A status write is held pending while the chip-select session stays open. It takes effect only when the session closes. If the protect pin goes low while the hardware lock is armed, a pending write is dropped. Once the write has been committed, the pin no longer matters. The two block-protect bits mark the top quarter, the top half or the whole array as read-only. A select bit redirects accesses to a 64-byte identification page, and a sticky lock bit makes that page read-only.

Top module: `sr_guard`

## Requirements
- R1: The status byte has this layout: bit 7 lock-arm, bit 6 id-page select, bit 5 constant 0, bit 4 id-page lock, bits 3:2 protect code, bit 1 write-enable latch, bit 0 ready/busy. With default parameters the byte reads 0x00 after reset.
- R2: A set strobe sets the write-enable latch and a clear strobe resets it. When both arrive in the same cycle, the clear wins. The latch also clears in the cycle after busy falls. Each change shows in the status byte one cycle after the strobe.
- R3: Protect code 00 guards nothing. Code 01 guards addresses at or above 3/4 of the array, code 10 guards the upper half, and code 11 guards every address.
- R4: The array permit flag is 1 one cycle after a cycle in which the write-enable latch is 1, busy is 0 and the address is not guarded. Otherwise it is 0.
- R5: A status write request with data D is accepted and held while the session is open. When the session closes, the block commits it. Only bits 7, 6, 4, 3 and 2 take their values from D, and the commit pulse is high for one cycle.
- R6: A status write with D[6] and D[4] both 1 changes neither bit. Once the id-page lock is 1, no status write clears it.
- R7: When lock-arm is 1 and the active-low protect pin is low, the status permit flag is 0 and status write requests are refused.
- R8: If the pin goes low with lock-arm set while a write is pending, the write is cancelled and no commit follows. A pin change after the commit does not affect the committed value.
- R9: The id-page select bit clears when the end-of-access strobe arrives.
- R10: While id-page select is 1, an array write is refused if the lock bit is 1, if the protect code is 11, or if the given address lies in the guarded range.
- R11: Bit 0 follows busy one cycle later. While busy is 1, the latch strobes and status write requests are ignored, and the array permit flag is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| guard_n | input | 1 | Active-low protect pin |
| sess_open | input | 1 | High while the chip-select session is open |
| wen_set | input | 1 | Write-enable set strobe |
| wen_clr | input | 1 | Write-enable clear strobe |
| busy | input | 1 | Internal write cycle in progress |
| stw_req | input | 1 | Status write request strobe |
| stw_data | input | 8 | Data byte of the status write |
| op_done | input | 1 | End of a memory read or write access |
| wr_addr | input | AW | Target address of an array write |
| status | output | 8 | Status byte |
| arr_wr_ok | output | 1 | Array write permitted (registered) |
| stw_ok | output | 1 | Status write permitted (registered) |
| stw_go | output | 1 | One-cycle pulse when a status write commits |

## Verification
A wrong protect code or lock bit shows up at the next status read. It also shows up one cycle later as a wrong array permit for an address just inside or just outside a guarded boundary, so the bench probes each boundary pair. A pending write that is wrongly kept or wrongly dropped shows up in the cycle after the session closes, as a commit pulse and a status byte that disagree with the expected value. The bench checks a write cancelled by the pin next to one that committed normally. A missed clear of the write-enable latch shows up in the status byte in the cycle after busy falls.

// File: rtl/sr_guard_pkg.sv
package sr_guard_pkg;
  localparam int SB_WPEN = 7;
  localparam int SB_IDS  = 6;
  localparam int SB_ZERO = 5;
  localparam int SB_LOCK = 4;
  localparam int SB_PC1  = 3;
  localparam int SB_PC0  = 2;
  localparam int SB_WEL  = 1;
  localparam int SB_RDY  = 0;

  // Fields that a status write may touch.
  typedef struct packed {
    logic       arm;
    logic       ids;
    logic       lock;
    logic [1:0] pcode;
  } sr_wfields_t;

  // Merge a requested field set into the current one.
  function automatic sr_wfields_t sr_apply(input sr_wfields_t cur,
                                           input sr_wfields_t req);
    sr_wfields_t res;
    res       = cur;
    res.arm   = req.arm;
    res.pcode = req.pcode;
    if (!(req.ids && req.lock)) begin
      res.ids  = req.ids;
      res.lock = cur.lock | req.lock;
    end
    return res;
  endfunction
endpackage

// File: rtl/sr_range_dec.sv
module sr_range_dec #(
  parameter int AW = 14
) (
  input  logic [1:0]    pcode,
  input  logic [AW-1:0] addr,
  output logic          hit
);
  localparam logic [AW-1:0] QTR_BASE  = AW'(3) << (AW - 2);
  localparam logic [AW-1:0] HALF_BASE = AW'(1) << (AW - 1);

  always_comb begin
    unique case (pcode)
      2'b00:   hit = 1'b0;
      2'b01:   hit = (addr >= QTR_BASE);
      2'b10:   hit = (addr >= HALF_BASE);
      default: hit = 1'b1;
    endcase
  end
endmodule

// File: rtl/sr_stw_track.sv
module sr_stw_track
  import sr_guard_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        load,
  input  sr_wfields_t load_val,
  input  logic        sess_open,
  input  logic        hwlock,
  output logic        commit,
  output sr_wfields_t held
);
  logic pend_q;

  assign commit = pend_q & ~sess_open & ~hwlock;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      held   <= '0;
    end else begin
      if (hwlock || (pend_q && !sess_open)) pend_q <= 1'b0;
      if (load) begin
        pend_q <= 1'b1;
        held   <= load_val;
      end
    end
  end
endmodule

// File: rtl/sr_guard.sv
module sr_guard
  import sr_guard_pkg::*;
#(
  parameter int         AW        = 14,
  parameter logic       INIT_ARM  = 1'b0,
  parameter logic [1:0] INIT_PC   = 2'b00,
  parameter logic       INIT_LOCK = 1'b0
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          guard_n,
  input  logic          sess_open,
  input  logic          wen_set,
  input  logic          wen_clr,
  input  logic          busy,
  input  logic          stw_req,
  input  logic [7:0]    stw_data,
  input  logic          op_done,
  input  logic [AW-1:0] wr_addr,
  output logic [7:0]    status,
  output logic          arr_wr_ok,
  output logic          stw_ok,
  output logic          stw_go
);
  sr_wfields_t fld_q, held, req_f;
  logic wel_q, rdy_q;
  logic hwlock, sw_permit, load, commit, prot_hit, id_ok, arr_permit;
  logic unused_bits;

  assign unused_bits = ^{stw_data[SB_ZERO], stw_data[SB_WEL], stw_data[SB_RDY]};

  assign req_f.arm   = stw_data[SB_WPEN];
  assign req_f.ids   = stw_data[SB_IDS];
  assign req_f.lock  = stw_data[SB_LOCK];
  assign req_f.pcode = stw_data[SB_PC1:SB_PC0];

  assign hwlock     = fld_q.arm & ~guard_n;
  assign sw_permit  = wel_q & ~busy & ~hwlock;
  assign load       = stw_req & sw_permit;
  assign id_ok      = ~fld_q.lock & (fld_q.pcode != 2'b11);
  assign arr_permit = wel_q & ~busy & ~prot_hit & (~fld_q.ids | id_ok);

  sr_range_dec #(.AW(AW)) i_range (
    .pcode (fld_q.pcode),
    .addr  (wr_addr),
    .hit   (prot_hit)
  );

  sr_stw_track i_track (
    .clk       (clk),
    .rst       (rst),
    .load      (load),
    .load_val  (req_f),
    .sess_open (sess_open),
    .hwlock    (hwlock),
    .commit    (commit),
    .held      (held)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      fld_q.arm   <= INIT_ARM;
      fld_q.ids   <= 1'b0;
      fld_q.lock  <= INIT_LOCK;
      fld_q.pcode <= INIT_PC;
      wel_q       <= 1'b0;
      rdy_q       <= 1'b0;
      arr_wr_ok   <= 1'b0;
      stw_ok      <= 1'b0;
      stw_go      <= 1'b0;
    end else begin
      rdy_q <= busy;
      if (rdy_q && !busy)  wel_q <= 1'b0;
      else if (!busy) begin
        if (wen_clr)       wel_q <= 1'b0;
        else if (wen_set)  wel_q <= 1'b1;
      end
      if (commit)          fld_q <= sr_apply(fld_q, held);
      else if (op_done)    fld_q.ids <= 1'b0;
      stw_go    <= commit;
      arr_wr_ok <= arr_permit;
      stw_ok    <= sw_permit;
    end
  end

  always_comb begin
    status          = '0;
    status[SB_WPEN] = fld_q.arm;
    status[SB_IDS]  = fld_q.ids;
    status[SB_LOCK] = fld_q.lock;
    status[SB_PC1:SB_PC0] = fld_q.pcode;
    status[SB_WEL]  = wel_q;
    status[SB_RDY]  = rdy_q;
  end
endmodule

// File: rtl/sr_guard_chk.sv
module sr_guard_chk (
  input logic       clk,
  input logic       rst,
  input logic       guard_n,
  input logic       busy,
  input logic [7:0] status,
  input logic       arr_wr_ok,
  input logic       stw_go
);
  AST_BIT5_LOW: assert property (@(posedge clk) disable iff (rst)
    status[5] == 1'b0);                                            // R1
  AST_NO_WEL_NO_ARR: assert property (@(posedge clk) disable iff (rst)
    !status[1] |=> !arr_wr_ok);                                    // R4
  AST_FULL_BLOCK: assert property (@(posedge clk) disable iff (rst)
    (status[3:2] == 2'b11) |=> !arr_wr_ok);                        // R3
  AST_HW_LOCK: assert property (@(posedge clk) disable iff (rst)
    (status[7] && !guard_n) |=> !stw_go);                          // R7
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (rst)
    status[4] |=> status[4]);                                      // R6
  AST_RDY_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (status[0] == $past(busy)));                          // R11
  AST_BUSY_NO_ARR: assert property (@(posedge clk) disable iff (rst)
    busy |=> !arr_wr_ok);                                          // R11
endmodule

bind sr_guard sr_guard_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .guard_n   (guard_n),
  .busy      (busy),
  .status    (status),
  .arr_wr_ok (arr_wr_ok),
  .stw_go    (stw_go)
);

// File: tb/test_sr_guard.sv
module test_sr_guard;
  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic guard_n = 1'b1, sess_open = 1'b0, wen_set = 1'b0, wen_clr = 1'b0;
  logic busy = 1'b0, stw_req = 1'b0, op_done = 1'b0;
  logic [7:0] stw_data = '0;
  logic [AW-1:0] wr_addr = '0;
  logic [7:0] status;
  logic arr_wr_ok, stw_ok, stw_go;

  int total = 0;
  int fails = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    int         kind;
    logic [7:0] exp;
  } item_t;
  item_t sb_q[$];

  always #5 clk = ~clk;

  sr_guard #(.AW(AW)) i_sr_guard (
    .clk(clk), .rst(rst), .guard_n(guard_n), .sess_open(sess_open),
    .wen_set(wen_set), .wen_clr(wen_clr), .busy(busy), .stw_req(stw_req),
    .stw_data(stw_data), .op_done(op_done), .wr_addr(wr_addr),
    .status(status), .arr_wr_ok(arr_wr_ok), .stw_ok(stw_ok), .stw_go(stw_go)
  );

  // Driver side: expectations for the outputs after the next rising edge.
  task automatic push(string tag, int kind, logic [7:0] e);
    item_t it;
    it.tag = tag; it.kind = kind; it.exp = e;
    sb_q.push_back(it);
  endtask
  task automatic x_st(string r, logic [7:0] e);  push(r, 0, e); endtask
  task automatic x_arr(string r, logic e);       push(r, 1, {7'd0, e}); endtask
  task automatic x_sw(string r, logic e);        push(r, 2, {7'd0, e}); endtask
  task automatic x_go(string r, logic e);        push(r, 3, {7'd0, e}); endtask

  task automatic step();
    @(negedge clk);
    wen_set = 0; wen_clr = 0; stw_req = 0; op_done = 0;
  endtask

  // Monitor: compare after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (sb_q.size() > 0) begin
        item_t it;
        logic [7:0] got;
        it = sb_q.pop_front();
        case (it.kind)
          0:       got = status;
          1:       got = {7'd0, arr_wr_ok};
          2:       got = {7'd0, stw_ok};
          default: got = {7'd0, stw_go};
        endcase
        total++;
        if (got !== it.exp) begin
          fails++;
          $display("FAIL %s kind%0d: got %h expected %h", it.tag, it.kind, got, it.exp);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    step(); rst = 0;
    x_st("R1", 8'h00); x_arr("R4", 0); x_sw("R4", 0);
    step(); wen_set = 1; x_st("R2", 8'h02);
    step(); wen_clr = 1; x_st("R2", 8'h00);
    step(); wen_set = 1; wen_clr = 1; x_st("R2", 8'h00);
    step(); wen_set = 1; x_st("R2", 8'h02);
    step(); wr_addr = 14'h3FFF; x_arr("R3", 1); x_sw("R7", 1);
    // status write 0xFF: both id bits requested -> neither changes
    step(); stw_req = 1; stw_data = 8'hFF; sess_open = 1; x_st("R5", 8'h02);
    step(); sess_open = 0; x_st("R5", 8'h8E); x_go("R5", 1);
    step(); busy = 1; wr_addr = 14'h0000; x_st("R11", 8'h8F); x_arr("R11", 0); x_go("R5", 0);
    step(); busy = 0; x_st("R2", 8'h8C);
    step(); wen_set = 1; x_st("R2", 8'h8E);
    step(); x_arr("R3", 0);
    // hardware lock
    step(); guard_n = 0; stw_req = 1; stw_data = 8'h04; sess_open = 1; x_sw("R7", 0);
    step(); guard_n = 1; sess_open = 0; x_go("R7", 0); x_st("R7", 8'h8E);
    // set code 01
    step(); stw_req = 1; stw_data = 8'h84; sess_open = 1;
    step(); sess_open = 0; x_st("R5", 8'h86); x_go("R5", 1);
    step(); busy = 1;
    step(); busy = 0; x_st("R2", 8'h84);
    step(); wen_set = 1; x_st("R2", 8'h86);
    step(); wr_addr = 14'h2FFF; x_arr("R3", 1);
    step(); wr_addr = 14'h3000; x_arr("R3", 0);
    // cancel by pin while pending
    step(); stw_req = 1; stw_data = 8'h88; sess_open = 1;
    step(); guard_n = 0;
    step(); guard_n = 1; sess_open = 0; x_go("R8", 0); x_st("R8", 8'h86);
    // commit, then pin has no effect
    step(); stw_req = 1; stw_data = 8'h88; sess_open = 1;
    step(); sess_open = 0; x_st("R8", 8'h8A); x_go("R8", 1);
    step(); guard_n = 0; busy = 1; x_st("R8", 8'h8B);
    step(); guard_n = 1; busy = 0; x_st("R8", 8'h88);
    step(); wen_set = 1; x_st("R2", 8'h8A);
    step(); wr_addr = 14'h1FFF; x_arr("R3", 1);
    step(); wr_addr = 14'h2000; x_arr("R3", 0);
    // id page select
    step(); stw_req = 1; stw_data = 8'h40; sess_open = 1;
    step(); sess_open = 0; x_st("R5", 8'h42); x_go("R5", 1);
    step(); busy = 1;
    step(); busy = 0; x_st("R2", 8'h40);
    step(); wen_set = 1; x_st("R2", 8'h42);
    step(); wr_addr = 14'h0005; x_arr("R10", 1);
    step(); op_done = 1; x_st("R9", 8'h02);
    step(); stw_req = 1; stw_data = 8'h44; sess_open = 1;
    step(); sess_open = 0; x_st("R5", 8'h46);
    step(); busy = 1;
    step(); busy = 0; x_st("R2", 8'h44);
    step(); wen_set = 1; x_st("R2", 8'h46);
    step(); wr_addr = 14'h3005; x_arr("R10", 0);
    step(); wr_addr = 14'h0005; x_arr("R10", 1);
    step(); op_done = 1; x_st("R9", 8'h06);
    // lock bit
    step(); stw_req = 1; stw_data = 8'h10; sess_open = 1;
    step(); sess_open = 0; x_st("R6", 8'h12);
    step(); busy = 1;
    step(); busy = 0; x_st("R2", 8'h10);
    step(); busy = 1; wen_set = 1; x_st("R11", 8'h11);
    step(); busy = 0; x_st("R11", 8'h10);
    step(); wen_set = 1; x_st("R2", 8'h12);
    step(); stw_req = 1; stw_data = 8'h40; sess_open = 1;
    step(); sess_open = 0; x_st("R6", 8'h52);
    step(); busy = 1;
    step(); busy = 0;
    step(); wen_set = 1; x_st("R6", 8'h52);
    step(); wr_addr = 14'h0001; x_arr("R10", 0);
    step(); step(); step();
    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule